// File: doc/BRIEF.md
# Single-Step Non-Restoring Divide Unit

This block executes one iteration of non-restoring binary division each time a step command is issued. It keeps three status flags: Q (sign of the running remainder), M (sign of the divisor) and T (the quotient bit just produced). A setup command prepares the flags before a division, either from the sign bits of the two operands (signed) or by clearing them (unsigned). A step command supplies the partial remainder and the divisor. One clock later the block returns the new partial remainder, updates Q and T, and pulses a done strobe.

The surrounding datapath keeps the dividend and the remainder. It runs the step 32 times. Before each step it rotates the dividend left through T: the old T goes into the dividend's low bit, and the dividend's top bit is written back into T with a flag-load command. After one final rotate, the dividend register holds the unsigned quotient.

The add or subtract decision does not depend on the sign of the remainder. It is taken from the previous Q and M. The quotient bit is reported on T as the result of comparing Q with M.

Top module: `divstep_unit`

## Requirements
- R1: During reset and after its release, rem_out, q_flag, m_flag, t_flag and step_done are all 0.
- R2: A signed setup (setup_go=1, setup_signed=1) sets q_flag to setup_dividend[31] and m_flag to setup_divisor[31], and sets t_flag to q_flag XOR m_flag, all on the next clock. It leaves rem_out unchanged.
- R3: An unsigned setup (setup_go=1, setup_signed=0) clears q_flag, m_flag and t_flag on the next clock.
- R4: A step first forms the shifted remainder {step_rem[30:0], t_flag}, which takes the current T into bit 0. With a zero divisor, rem_out equals this value.
- R5: A step subtracts step_divisor from the shifted remainder when the previous q_flag equals m_flag, and adds it otherwise. The 32-bit result appears on rem_out one clock later.
- R6: After a step, q_flag equals step_rem[31] XOR m_flag XOR the carry-out of the add or the borrow of the subtract.
- R7: After a step, t_flag is 1 exactly when the new q_flag equals m_flag. m_flag is not changed by a step.
- R8: step_done is 1 for exactly the one cycle after each accepted step command, and 0 at every other time.
- R9: Setup has priority. If setup_go and step_go are both high, only the setup takes effect: rem_out is held and step_done stays 0.
- R10: In a cycle with no command, rem_out, q_flag, m_flag and t_flag keep their values.
- R11: An unsigned setup is followed by 32 iterations, each made of a rotate-left of the dividend through T and then a step with the running remainder (starting from 0). One final rotate after the 32 iterations leaves floor(dividend/divisor) in the dividend.
- R12: A flag-load command (tload_go=1, with no setup or step in the same cycle) writes tload_val into t_flag and leaves q_flag, m_flag and rem_out unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| setup_go | input | 1 | Setup command |
| setup_signed | input | 1 | 1: signed setup from operand signs; 0: clear flags |
| setup_dividend | input | 32 | Dividend (only its sign bit is used) |
| setup_divisor | input | 32 | Divisor (only its sign bit is used) |
| step_go | input | 1 | Step command |
| step_rem | input | 32 | Incoming partial remainder |
| step_divisor | input | 32 | Divisor used for this step |
| tload_go | input | 1 | Flag-load command for T |
| tload_val | input | 1 | Value written into T |
| rem_out | output | 32 | Partial remainder from the last step |
| q_flag | output | 1 | Q flag |
| m_flag | output | 1 | M flag |
| t_flag | output | 1 | T flag (quotient bit) |
| step_done | output | 1 | One-cycle pulse after a step |

## Verification
The bench drives all four add/subtract selections and carry-outs on both sides of the 32-bit boundary. A design that chose the operation from the remainder's sign, or that dropped the carry from the Q update, would put a wrong remainder or a wrong Q on the ports in that same cycle.

It sends setup and step in the same cycle to catch a reversed priority, which would show up as a changed remainder or a stray done pulse. It inserts a non-zero T into bit 0 so that a shift which loses the old T is caught.

Full 32-step unsigned divisions are run with divisors of 1 and all-ones, and with dividends smaller than the divisor. A wrong Q or T update in any one step would corrupt the final quotient.

// File: rtl/divstep_pkg.sv
package divstep_pkg;
  typedef enum logic [1:0] {
    CMD_IDLE  = 2'd0,
    CMD_SETUP = 2'd1,
    CMD_STEP  = 2'd2,
    CMD_TLOAD = 2'd3
  } divstep_cmd_e;
endpackage

// File: rtl/divstep_alu.sv
module divstep_alu #(
  parameter int W = 32
) (
  input  logic [W-1:0] rem_in,
  input  logic [W-1:0] dvsr,
  input  logic         t_in,
  input  logic         q_prev,
  input  logic         m_in,
  output logic [W-1:0] rem_next,
  output logic         q_next,
  output logic         t_next,
  output logic         sub_sel,
  output logic         cy_out
);
  localparam int MSB = W - 1;

  // left shift with the current quotient bit entering at bit 0
  function automatic logic [W-1:0] shift_in(input logic [W-1:0] r, input logic b);
    return {r[MSB-1:0], b};
  endfunction

  // returns {carry_or_borrow, result}
  function automatic logic [W:0] add_sub(input logic [W-1:0] a, input logic [W-1:0] b,
                                         input logic sub);
    logic [W:0] s;
    if (sub) s = {1'b0, a} - {1'b0, b};
    else     s = {1'b0, a} + {1'b0, b};
    return s;
  endfunction

  logic [W-1:0] shifted;
  logic [W:0]   sum;

  assign shifted  = shift_in(rem_in, t_in);
  assign sub_sel  = (q_prev == m_in);
  assign sum      = add_sub(shifted, dvsr, sub_sel);
  assign rem_next = sum[MSB:0];
  assign cy_out   = sum[W];
  assign q_next   = rem_in[MSB] ^ m_in ^ cy_out;
  assign t_next   = (q_next == m_in);
endmodule

// File: rtl/divstep_flags.sv
module divstep_flags
  import divstep_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  divstep_cmd_e cmd,
  input  logic         setup_signed,
  input  logic         dvd_msb,
  input  logic         dvs_msb,
  input  logic         q_next,
  input  logic         t_next,
  input  logic         tload_val,
  output logic         q,
  output logic         m,
  output logic         t
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= 1'b0;
      m <= 1'b0;
      t <= 1'b0;
    end else begin
      unique case (cmd)
        CMD_SETUP: begin
          if (setup_signed) begin
            q <= dvd_msb;
            m <= dvs_msb;
            t <= dvd_msb ^ dvs_msb;
          end else begin
            q <= 1'b0;
            m <= 1'b0;
            t <= 1'b0;
          end
        end
        CMD_STEP: begin
          q <= q_next;
          t <= t_next;
        end
        CMD_TLOAD: t <= tload_val;
        default: ;
      endcase
    end
  end

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd == CMD_IDLE |=> $stable(q) && $stable(m) && $stable(t));

  p_unsigned_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_SETUP && !setup_signed) |=> (!q && !m && !t));

  p_signed_t_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_SETUP && setup_signed) |=> (t == (q ^ m)));

  p_step_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd == CMD_STEP |=> $stable(m) && (t == (q == m)));

  p_tload_r12: assert property (@(posedge clk) disable iff (!rst_n)
    cmd == CMD_TLOAD |=> (t == $past(tload_val)) && $stable(q) && $stable(m));
endmodule

// File: rtl/divstep_unit.sv
module divstep_unit
  import divstep_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         setup_go,
  input  logic         setup_signed,
  input  logic [W-1:0] setup_dividend,
  input  logic [W-1:0] setup_divisor,
  input  logic         step_go,
  input  logic [W-1:0] step_rem,
  input  logic [W-1:0] step_divisor,
  input  logic         tload_go,
  input  logic         tload_val,
  output logic [W-1:0] rem_out,
  output logic         q_flag,
  output logic         m_flag,
  output logic         t_flag,
  output logic         step_done
);
  localparam int MSB = W - 1;

  divstep_cmd_e cmd;
  logic [W-1:0] rem_next;
  logic         q_next, t_next, sub_sel, cy_out;
  logic [W-1:0] rem_q;
  logic         done_q;

  // priority: setup, then step, then flag load
  always_comb begin
    if (setup_go)      cmd = CMD_SETUP;
    else if (step_go)  cmd = CMD_STEP;
    else if (tload_go) cmd = CMD_TLOAD;
    else               cmd = CMD_IDLE;
  end

  divstep_alu #(.W(W)) u_alu (
    .rem_in   (step_rem),
    .dvsr     (step_divisor),
    .t_in     (t_flag),
    .q_prev   (q_flag),
    .m_in     (m_flag),
    .rem_next (rem_next),
    .q_next   (q_next),
    .t_next   (t_next),
    .sub_sel  (sub_sel),
    .cy_out   (cy_out)
  );

  divstep_flags u_flags (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd          (cmd),
    .setup_signed (setup_signed),
    .dvd_msb      (setup_dividend[MSB]),
    .dvs_msb      (setup_divisor[MSB]),
    .q_next       (q_next),
    .t_next       (t_next),
    .tload_val    (tload_val),
    .q            (q_flag),
    .m            (m_flag),
    .t            (t_flag)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= (cmd == CMD_STEP);
      if (cmd == CMD_STEP) rem_q <= rem_next;
    end
  end

  assign rem_out   = rem_q;
  assign step_done = done_q;

  p_done_after_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    step_go && !setup_go |=> step_done);

  p_no_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(step_go && !setup_go) |=> !step_done);

  p_rem_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(step_go && !setup_go) |=> $stable(rem_out));

  p_sub_choice_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step_go && !setup_go && sub_sel) |-> (q_flag == m_flag));
endmodule

// File: tb/divstep_unit_test.sv
module divstep_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         setup_go = 1'b0, setup_signed = 1'b0;
  logic [W-1:0] setup_dividend = '0, setup_divisor = '0;
  logic         step_go = 1'b0;
  logic [W-1:0] step_rem = '0, step_divisor = '0;
  logic         tload_go = 1'b0, tload_val = 1'b0;
  logic [W-1:0] rem_out;
  logic         q_flag, m_flag, t_flag, step_done;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  divstep_unit #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n),
    .setup_go(setup_go), .setup_signed(setup_signed),
    .setup_dividend(setup_dividend), .setup_divisor(setup_divisor),
    .step_go(step_go), .step_rem(step_rem), .step_divisor(step_divisor),
    .tload_go(tload_go), .tload_val(tload_val),
    .rem_out(rem_out), .q_flag(q_flag), .m_flag(m_flag), .t_flag(t_flag),
    .step_done(step_done)
  );

  task automatic check(input string tag, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference state
  longint mrem = 0;
  bit mq = 0, mm = 0, mt = 0, mdone = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mrem = 0; mq = 0; mm = 0; mt = 0; mdone = 0;
    end else begin
      mdone = 0;
      if (setup_go) begin
        if (setup_signed) begin
          mq = setup_dividend[W-1];
          mm = setup_divisor[W-1];
          mt = mq ^ mm;
        end else begin
          mq = 0; mm = 0; mt = 0;
        end
      end else if (step_go) begin
        longint sh, s;
        bit cb;
        sh = ((longint'(step_rem) * 2) % (64'd1 << W)) + (mt ? 1 : 0);
        if (mq == mm) begin
          s  = sh - longint'(step_divisor);
          cb = (s < 0);
          if (s < 0) s = s + (64'd1 << W);
        end else begin
          s  = sh + longint'(step_divisor);
          cb = (s >= (64'd1 << W));
          if (cb) s = s - (64'd1 << W);
        end
        mrem = s;
        mq = step_rem[W-1] ^ mm ^ cb;
        mt = (mq == mm);
        mdone = 1;
      end else if (tload_go) begin
        mt = tload_val;
      end
    end
  end

  // compare against the model on every cycle
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check("R5 rem_out vs model", longint'(rem_out), mrem);
      check("R6 q_flag vs model", longint'(q_flag), longint'(mq));
      check("R2 m_flag vs model", longint'(m_flag), longint'(mm));
      check("R7 t_flag vs model", longint'(t_flag), longint'(mt));
      check("R8 step_done vs model", longint'(step_done), longint'(mdone));
    end
  end

  // all tasks start and end at a falling edge
  task automatic do_setup(input bit sgn, input logic [W-1:0] a, input logic [W-1:0] b);
    setup_go = 1; setup_signed = sgn; setup_dividend = a; setup_divisor = b;
    @(negedge clk);
    setup_go = 0;
  endtask

  task automatic do_step(input logic [W-1:0] r, input logic [W-1:0] d);
    step_go = 1; step_rem = r; step_divisor = d;
    @(negedge clk);
    step_go = 0;
  endtask

  task automatic do_tload(input bit v);
    tload_go = 1; tload_val = v;
    @(negedge clk);
    tload_go = 0;
  endtask

  task automatic do_udiv(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W-1:0] r0, rem;
    bit top;
    r0 = a; rem = '0;
    do_setup(0, '0, '0);
    for (int i = 0; i < W; i++) begin
      top = r0[W-1];
      r0 = {r0[W-2:0], t_flag};
      do_tload(top);
      do_step(rem, b);
      rem = rem_out;
    end
    r0 = {r0[W-2:0], t_flag};
    check("R11 quotient", longint'(r0), longint'(a / b));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired");
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] held;
    repeat (3) @(negedge clk);
    // R1: reset values
    check("R1 rem_out", longint'(rem_out), 0);
    check("R1 flags", longint'({q_flag, m_flag, t_flag, step_done}), 0);
    rst_n = 1;
    @(negedge clk);
    check("R1 after release", longint'({rem_out, q_flag, m_flag, t_flag, step_done}), 0);

    // R2: signed setup
    do_setup(1, 32'h8000_0000, 32'h0000_0005);
    check("R2 q", q_flag, 1); check("R2 m", m_flag, 0); check("R2 t", t_flag, 1);
    check("R2 rem_out held", longint'(rem_out), 0);
    // R4: T enters bit 0, zero divisor
    do_step(32'h4000_0001, 32'h0);
    check("R4 shifted", longint'(rem_out), 64'h8000_0003);
    check("R8 done pulse", step_done, 1);
    @(negedge clk);
    check("R8 done drops", step_done, 0);

    // R3: unsigned setup clears
    do_setup(0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    check("R3 flags cleared", longint'({q_flag, m_flag, t_flag}), 0);
    // R5 subtract path: 0x20 - 5
    do_step(32'h0000_0010, 32'h0000_0005);
    check("R5 subtract", longint'(rem_out), 64'h1B);
    check("R6 q after sub", q_flag, 0);
    check("R7 t after sub", t_flag, 1);

    // R5 add path with carry: Q=0, M=1, T=1
    do_setup(1, 32'h0, 32'h8000_0000);
    do_step(32'h0000_0003, 32'hFFFF_FFFE);
    check("R5 add", longint'(rem_out), 5);
    check("R6 q after add", q_flag, 0);
    check("R7 t after add", t_flag, 0);
    check("R7 m kept", m_flag, 1);

    // R9: setup and step together
    held = rem_out;
    setup_go = 1; setup_signed = 0; step_go = 1; step_rem = 32'hFFFF; step_divisor = 32'h1;
    @(negedge clk);
    setup_go = 0; step_go = 0;
    check("R9 rem held", longint'(rem_out), longint'(held));
    check("R9 no done", step_done, 0);
    check("R9 setup applied", longint'({q_flag, m_flag, t_flag}), 0);

    // R12: flag load
    do_setup(1, 32'h8000_0000, 32'h8000_0000);
    do_tload(1);
    check("R12 t loaded", t_flag, 1);
    check("R12 q m kept", longint'({q_flag, m_flag}), 3);
    check("R12 rem kept", longint'(rem_out), longint'(held));

    // R10: idle cycles
    repeat (3) @(negedge clk);
    check("R10 idle hold", longint'({rem_out, q_flag, m_flag, t_flag}),
          longint'({held, 3'b111}));

    // R11: full unsigned divisions
    do_udiv(32'd100, 32'd7);
    do_udiv(32'hFFFF_FFFF, 32'd1);
    do_udiv(32'hFFFF_FFFF, 32'hFFFF_FFFF);
    do_udiv(32'd5, 32'd9);
    do_udiv(32'h8000_0000, 32'h8000_0001);
    do_udiv(32'h1234_5678, 32'h0000_0100);
    for (int k = 0; k < 12; k++) begin
      logic [W-1:0] a, b;
      a = $urandom;
      b = $urandom >> (k % 31);
      if (b == 0) b = 1;
      do_udiv(a, b);
    end

    // mixed random commands, checked by the per-cycle model
    for (int k = 0; k < 300; k++) begin
      int c;
      c = $urandom % 5;
      setup_go = (c == 0) || (($urandom % 16) == 0);
      setup_signed = $urandom; setup_dividend = $urandom; setup_divisor = $urandom;
      step_go = (c >= 2); step_rem = $urandom; step_divisor = $urandom;
      tload_go = (c == 1); tload_val = $urandom;
      @(negedge clk);
    end
    setup_go = 0; step_go = 0; tload_go = 0;
    @(negedge clk);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule